// File: doc/BRIEF.md
# Pulsed Overcurrent and Thermal Protection Controller

This block supervises a supply output stage. It takes an overload indication that is already digitized, a thermal alarm that already has its hysteresis applied, a bit that chooses the clamp mode and a master enable bit. From these it drives the power-stage enable, the control of a bypass switch that routes supply from an upstream source when the stage is idle, and two diagnostic flags: one for overload and one for overtemperature.

There are two ways to handle an overload. In clamp mode the stage keeps running and the overload flag simply follows the overload input. In hiccup mode an overload switches the stage off for a long interval and then back on for a window one tenth as long. The stage returns to normal running only after a whole window passes with no overload seen. If any overload appears during the window, a new off interval begins. Overtemperature takes priority over every other condition. It turns the stage off, opens the bypass switch and clears any hiccup cycle that is in progress.

The off interval is given in clock cycles by the parameter `OFF_CYCLES`. The on window is `OFF_CYCLES/10`. Every output is registered, so the outputs respond on the clock edge that follows the one at which the inputs were sampled.

Top module: `ovp_supervisor`

## Requirements
- R1: While reset is asserted and after it is released, with enable low, the outputs are power enable 0, bypass closed 1, overload flag 0 and thermal flag 0.
- R2: With enable high, no overload and no thermal alarm, the next cycle shows power enable 1, bypass closed 0 and both flags 0.
- R3: In hiccup mode (clamp select 0), an overload sampled while running sets power enable to 0 and the overload flag to 1 on the next cycle. Power enable then stays 0 for exactly OFF_CYCLES cycles, even if the overload goes away.
- R4: After the off interval, power enable is 1 for an on window of OFF_CYCLES/10 cycles, and the overload flag stays 1 during it. If the window had no overload, the flag is 0 from the following cycle and power enable stays 1.
- R5: An overload sampled in any cycle of the on window, including a single-cycle pulse or one that persists to the end of the window, starts a new off interval of power enable 0 right after the window.
- R6: In clamp mode (clamp select 1), power enable stays 1 during overload. The overload flag equals the overload input of the previous cycle.
- R7: Changing clamp select from 1 to 0 while an overload is present turns power off on the next cycle. Changing clamp select from 0 to 1 during an off interval turns power back on on the next cycle.
- R8: A thermal alarm sets the thermal flag to 1, power enable to 0, bypass closed to 0 and the overload flag to 0 on the next cycle, whatever the enable or overload state. When the alarm clears, the stage runs again and a new overload gets a full-length off interval.
- R9: With enable low and no thermal alarm, the next cycle shows power enable 0, bypass closed 1 and both flags 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ovl_i | input | 1 | Digitized overload indication |
| hot_i | input | 1 | Overtemperature indication, hysteresis already applied |
| clamp_sel_i | input | 1 | 1 = static clamp mode, 0 = hiccup mode |
| enable_i | input | 1 | Master enable for the power stage |
| pwr_en_o | output | 1 | Power-stage enable |
| bypass_close_o | output | 1 | 1 closes the bypass switch |
| ovl_flag_o | output | 1 | Overload diagnostic flag |
| hot_flag_o | output | 1 | Overtemperature diagnostic flag |

## Verification
A wrong state in the sequencer or a timer that is off by even one count shows up at power enable. The off interval or the on window would come out one cycle longer or shorter than required. The bench measures both by counting cycles at the port. If the window flag fails to remember a brief overload, the stage resumes running when it should go dark, and this is visible one cycle after the window closes. Errors in priority, such as thermal versus enable or mode changes in the middle of a cycle, appear on the cycle right after the input changes. That is where each check samples.

// File: rtl/ovp_pkg.sv
package ovp_pkg;
  typedef enum logic [2:0] {
    ST_DIS = 3'd0,
    ST_RUN = 3'd1,
    ST_OFF = 3'd2,
    ST_ON  = 3'd3,
    ST_HOT = 3'd4
  } ovp_state_e;
endpackage

// File: rtl/ovp_interval_timer.sv
module ovp_interval_timer #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear_i,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          expired_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) cnt_q <= '0;
    else if (load_i)    cnt_q <= load_val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  AST_TIMER_IDLE_STAYS: assert property (@(posedge clk) disable iff (rst)
    (expired_o && !load_i) |=> expired_o); // R3
endmodule

// File: rtl/ovp_hiccup_fsm.sv
module ovp_hiccup_fsm
  import ovp_pkg::*;
#(
  parameter int OFF_CYCLES = 1000,
  parameter int CW = $clog2(OFF_CYCLES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ovl_i,
  input  logic          hot_i,
  input  logic          clamp_sel_i,
  input  logic          enable_i,
  input  logic          expired_i,
  output ovp_state_e    nxt_o,
  output logic          load_o,
  output logic          clear_o,
  output logic [CW-1:0] load_val_o
);
  localparam int ON_CYCLES = OFF_CYCLES / 10;
  localparam logic [CW-1:0] OFF_LOAD = CW'(OFF_CYCLES - 1);
  localparam logic [CW-1:0] ON_LOAD  = CW'(ON_CYCLES - 1);

  ovp_state_e state_q, nxt;
  logic       dirty_q;

  always_comb begin
    nxt = state_q;
    if (hot_i) nxt = ST_HOT;
    else if (!enable_i) nxt = ST_DIS;
    else begin
      case (state_q)
        ST_DIS, ST_HOT: nxt = ST_RUN;
        ST_RUN: if (ovl_i && !clamp_sel_i) nxt = ST_OFF;
        ST_OFF: begin
          if (clamp_sel_i) nxt = ST_RUN;
          else if (expired_i) nxt = ST_ON;
        end
        ST_ON: begin
          if (clamp_sel_i) nxt = ST_RUN;
          else if (expired_i) nxt = (dirty_q || ovl_i) ? ST_OFF : ST_RUN;
        end
        default: nxt = ST_DIS;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_DIS;
      dirty_q <= 1'b0;
    end else begin
      state_q <= nxt;
      if (state_q != ST_ON) dirty_q <= 1'b0;
      else if (ovl_i)       dirty_q <= 1'b1;
    end
  end

  assign nxt_o      = nxt;
  assign load_o     = ((nxt == ST_OFF) && (state_q != ST_OFF)) ||
                      ((nxt == ST_ON)  && (state_q != ST_ON));
  assign load_val_o = (nxt == ST_OFF) ? OFF_LOAD : ON_LOAD;
  assign clear_o    = (nxt == ST_HOT) || (nxt == ST_DIS);

  AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_OFF && !expired_i && enable_i && !hot_i && !clamp_sel_i)
      |=> (state_q == ST_OFF)); // R3
endmodule

// File: rtl/ovp_supervisor.sv
module ovp_supervisor
  import ovp_pkg::*;
#(
  parameter int OFF_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic ovl_i,
  input  logic hot_i,
  input  logic clamp_sel_i,
  input  logic enable_i,
  output logic pwr_en_o,
  output logic bypass_close_o,
  output logic ovl_flag_o,
  output logic hot_flag_o
);
  localparam int CW = $clog2(OFF_CYCLES);

  ovp_state_e    nxt;
  logic          load, clear, expired;
  logic [CW-1:0] load_val;

  ovp_hiccup_fsm #(.OFF_CYCLES(OFF_CYCLES), .CW(CW)) u_fsm (
    .clk(clk), .rst(rst), .ovl_i(ovl_i), .hot_i(hot_i),
    .clamp_sel_i(clamp_sel_i), .enable_i(enable_i), .expired_i(expired),
    .nxt_o(nxt), .load_o(load), .clear_o(clear), .load_val_o(load_val)
  );

  ovp_interval_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .clear_i(clear), .load_i(load),
    .load_val_i(load_val), .expired_o(expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pwr_en_o       <= 1'b0;
      bypass_close_o <= 1'b1;
      ovl_flag_o     <= 1'b0;
      hot_flag_o     <= 1'b0;
    end else begin
      pwr_en_o       <= (nxt == ST_RUN) || (nxt == ST_ON);
      bypass_close_o <= (nxt == ST_DIS);
      hot_flag_o     <= (nxt == ST_HOT);
      ovl_flag_o     <= (nxt == ST_OFF) || (nxt == ST_ON) ||
                        ((nxt == ST_RUN) && clamp_sel_i && ovl_i);
    end
  end

  AST_HOT_WINS: assert property (@(posedge clk) disable iff (rst)
    hot_i |=> (hot_flag_o && !pwr_en_o && !bypass_close_o && !ovl_flag_o)); // R8
  AST_DISABLED: assert property (@(posedge clk) disable iff (rst)
    (!enable_i && !hot_i) |=> (bypass_close_o && !pwr_en_o && !ovl_flag_o)); // R9
  AST_CLAMP_TRACKS: assert property (@(posedge clk) disable iff (rst)
    (enable_i && clamp_sel_i && !hot_i && pwr_en_o)
      |=> (pwr_en_o && (ovl_flag_o == $past(ovl_i)))); // R6
  AST_BYPASS_EXCL: assert property (@(posedge clk) disable iff (rst)
    bypass_close_o |-> !pwr_en_o); // R9
endmodule

// File: tb/ovp_supervisor_tb.sv
module ovp_supervisor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int OFF_N = 40;
  localparam int ON_N  = OFF_N / 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ovl = 1'b0, hot = 1'b0, clamp = 1'b0, en = 1'b0;
  logic pwr, byp, olf, otf;
  int n_tests = 0;
  int n_fail  = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ovp_supervisor #(.OFF_CYCLES(OFF_N)) u_dut (
    .clk(clk), .rst(rst), .ovl_i(ovl), .hot_i(hot), .clamp_sel_i(clamp),
    .enable_i(en), .pwr_en_o(pwr), .bypass_close_o(byp),
    .ovl_flag_o(olf), .hot_flag_o(otf)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic count_low(output int n);
    n = 0;
    while (!pwr && n < 1000) begin n++; step(); end
  endtask

  task automatic count_window(output int n);
    n = 0;
    while (pwr && olf && n < 1000) begin n++; step(); end
  endtask

  task automatic settle_run();
    ovl = 1'b0;
    for (int i = 0; i < 200 && !(pwr && !olf); i++) step();
  endtask

  task automatic t_reset();
    step();
    chk("R1", "pwr", pwr, 0); chk("R1", "bypass", byp, 1);
    chk("R1", "olf", olf, 0); chk("R1", "otf", otf, 0);
    rst = 1'b0; step();
    chk("R1", "bypass after release", byp, 1);
    chk("R1", "pwr after release", pwr, 0);
  endtask

  task automatic t_enable();
    en = 1'b1; step();
    chk("R2", "pwr", pwr, 1); chk("R2", "bypass", byp, 0);
    chk("R2", "olf", olf, 0); chk("R2", "otf", otf, 0);
  endtask

  task automatic t_hiccup_clean();
    int n;
    ovl = 1'b1; step();
    chk("R3", "pwr off", pwr, 0); chk("R3", "olf set", olf, 1);
    ovl = 1'b0;
    count_low(n);   chk("R3", "off length", n, OFF_N);
    count_window(n); chk("R4", "on window", n, ON_N);
    chk("R4", "pwr after clean window", pwr, 1);
    chk("R4", "olf cleared", olf, 0);
  endtask

  task automatic t_hiccup_persist();
    int n;
    ovl = 1'b1; step();
    count_low(n);    chk("R5", "off length persistent", n, OFF_N);
    count_window(n); chk("R5", "on window persistent", n, ON_N);
    chk("R5", "off again", pwr, 0);
    settle_run();
    chk("R5", "recovered", pwr, 1);
  endtask

  task automatic t_hiccup_glitch();
    int n;
    ovl = 1'b1; step(); ovl = 1'b0;
    count_low(n);
    n = 1; ovl = 1'b1; step(); ovl = 1'b0;
    while (pwr && n < 100) begin n++; step(); end
    chk("R5", "window with glitch", n, ON_N);
    chk("R5", "off after glitch", pwr, 0);
    chk("R5", "olf during reoff", olf, 1);
    settle_run();
  endtask

  task automatic t_clamp();
    clamp = 1'b1; ovl = 1'b1; step();
    chk("R6", "pwr stays", pwr, 1); chk("R6", "olf follows 1", olf, 1);
    ovl = 1'b0; step();
    chk("R6", "olf follows 0", olf, 0); chk("R6", "pwr", pwr, 1);
  endtask

  task automatic t_mode_switch();
    ovl = 1'b1; step();
    chk("R7", "clamp pwr", pwr, 1);
    clamp = 1'b0; step();
    chk("R7", "hiccup starts", pwr, 0);
    step(); step();
    clamp = 1'b1; step();
    chk("R7", "back to clamp pwr", pwr, 1);
    chk("R7", "back to clamp olf", olf, 1);
    ovl = 1'b0; step();
    chk("R7", "olf cleared", olf, 0);
    clamp = 1'b0;
  endtask

  task automatic t_hot();
    int n;
    ovl = 1'b1; step(); ovl = 1'b0; step(); step();
    hot = 1'b1; step();
    chk("R8", "otf", otf, 1); chk("R8", "pwr", pwr, 0);
    chk("R8", "bypass open", byp, 0); chk("R8", "olf", olf, 0);
    en = 1'b0; step();
    chk("R8", "hot over disable bypass", byp, 0);
    chk("R8", "hot over disable otf", otf, 1);
    en = 1'b1; hot = 1'b0; step();
    chk("R8", "resume pwr", pwr, 1); chk("R8", "otf clear", otf, 0);
    ovl = 1'b1; step(); ovl = 1'b0;
    count_low(n); chk("R8", "fresh off length", n, OFF_N);
    settle_run();
  endtask

  task automatic t_disable();
    ovl = 1'b1; en = 1'b0; step();
    chk("R9", "pwr", pwr, 0); chk("R9", "bypass", byp, 1);
    chk("R9", "olf", olf, 0); chk("R9", "otf", otf, 0);
    ovl = 1'b0;
  endtask

  initial begin
    t_reset();
    t_enable();
    t_hiccup_clean();
    t_hiccup_persist();
    t_hiccup_glitch();
    t_clamp();
    t_mode_switch();
    t_hot();
    t_disable();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule